// File: doc/BRIEF.md
# Dual-Master Output Bank With Atomic Bit Aliases

This block holds a word of general-purpose output bits that two independent bus masters share, for example a host processor and a real-time coprocessor. Each master has its own simple register port (write strobe, read strobe, word address, write data, read data). Through that port a master can reach three addresses. The first replaces the whole output word. The second sets exactly the bits written as one. The third clears exactly the bits written as one.

Because a set or clear takes a single write and needs no read first, two masters can flip their own bits at the same time with no lock, and no update is lost. When both masters write in the same clock cycle, the block merges their requests in one step. Full-word writes are applied first. All set masks and all clear masks are then applied on top of that result, and clear wins over set on the same bit. The output pins come straight from the data register. A read returns the data value registered one cycle after the read strobe.

Top module: `gpio_dual_bank`

## Requirements
- R1: After synchronous active-high reset the data register, the pins and both read ports are all zeros.
- R2: A write to byte offset 0x13C (word address 0x4F) replaces every output bit with the write data on the next clock edge.
- R3: A write to offset 0x194 (word address 0x65) sets to 1 exactly the bits written as 1. All other bits keep their value.
- R4: A write to offset 0x190 (word address 0x64) clears to 0 exactly the bits written as 1. All other bits keep their value.
- R5: Same-cycle set and clear masks from both masters are merged bitwise, and clear has priority over set on a shared bit.
- R6: A full-word write in a cycle is applied first, and any set or clear masks from the same cycle are applied on top of it.
- R7: If both masters write the full-word address in the same cycle, master 0's data is used for the whole word.
- R8: A read of any of the three addresses returns, on the next cycle, the data value held before any write made in the read cycle.
- R9: A write to any other address has no effect on the outputs. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_wr | input | 1 | Master 0 write strobe |
| m0_rd | input | 1 | Master 0 read strobe |
| m0_addr | input | 10 | Master 0 word address (byte offset / 4) |
| m0_wdata | input | 32 | Master 0 write data |
| m0_rdata | output | 32 | Master 0 registered read data |
| m1_wr | input | 1 | Master 1 write strobe |
| m1_rd | input | 1 | Master 1 read strobe |
| m1_addr | input | 10 | Master 1 word address (byte offset / 4) |
| m1_wdata | input | 32 | Master 1 write data |
| m1_rdata | output | 32 | Master 1 registered read data |
| gpio_out | output | 32 | Output pin levels |

## Verification
Directed patterns come first. They drive each alias alone with sparse and dense masks, which separates set from clear from full-word behaviour. They then drive the two masters on the same bit and on disjoint bits. This shows whether clear beats set and whether a bit from one master is lost. Full-word writes are paired with same-cycle masks and with a second full-word write, which exposes the wrong application order and the wrong winner. A long random phase follows, with concurrent set, clear, data and stray-address traffic from both masters. It is checked every cycle against a behavioural model. Any lost bit update shows up as a mismatch on the pins or on a read port.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam logic [ADDR_W-1:0] WA_DATA = 10'h04F; // byte 0x13C
  localparam logic [ADDR_W-1:0] WA_CLR  = 10'h064; // byte 0x190
  localparam logic [ADDR_W-1:0] WA_SET  = 10'h065; // byte 0x194

  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_SET, OP_CLR} op_e;
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic              load_en,
  output logic [WIDTH-1:0]  load_val,
  output logic [WIDTH-1:0]  set_mask,
  output logic [WIDTH-1:0]  clr_mask
);
  op_e op;

  always_comb begin
    op = OP_NONE;
    if (wr) begin
      unique case (addr)
        WA_DATA: op = OP_LOAD;
        WA_SET:  op = OP_SET;
        WA_CLR:  op = OP_CLR;
        default: op = OP_NONE;
      endcase
    end
  end

  assign load_en  = (op == OP_LOAD);
  assign load_val = wdata;
  assign set_mask = (op == OP_SET) ? wdata : '0;
  assign clr_mask = (op == OP_CLR) ? wdata : '0;
endmodule

// File: rtl/gpio_merge.sv
module gpio_merge #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NMST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NMST-1:0]  load_en,
  input  logic [WIDTH-1:0] load_val [NMST],
  input  logic [WIDTH-1:0] set_mask [NMST],
  input  logic [WIDTH-1:0] clr_mask [NMST],
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] base, set_all, clr_all, nxt;

  always_comb begin
    base    = q;
    set_all = '0;
    clr_all = '0;
    // lowest index wins a full-word load: iterate from high to low
    for (int i = NMST - 1; i >= 0; i--) begin
      if (load_en[i]) base = load_val[i];
    end
    for (int i = 0; i < NMST; i++) begin
      set_all = set_all | set_mask[i];
      clr_all = clr_all | clr_mask[i];
    end
    nxt = (base | set_all) & ~clr_all;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en == '0 && set_mask[0] != '0 && clr_mask[1] == '0 && clr_mask[0] == '0)
      |=> ((q & $past(set_mask[0])) == $past(set_mask[0])));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_mask[1] != '0) |=> ((q & $past(clr_mask[1])) == '0));
  // R7
  load_win_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en == 2'b11 && set_mask[0] == '0 && set_mask[1] == '0
     && clr_mask[0] == '0 && clr_mask[1] == '0)
      |=> (q == $past(load_val[0])));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en == '0 && set_mask[0] == '0 && set_mask[1] == '0
     && clr_mask[0] == '0 && clr_mask[1] == '0) |=> $stable(q));
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  cur,
  output logic [WIDTH-1:0]  rdata
);
  logic hit;
  assign hit = rd && (addr == WA_DATA || addr == WA_SET || addr == WA_CLR);

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (hit) rdata <= cur;
    else          rdata <= '0;
  end

  // R8
  rd_old_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (rdata == $past(cur)));
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m0_wr,
  input  logic              m0_rd,
  input  logic [ADDR_W-1:0] m0_addr,
  input  logic [WIDTH-1:0]  m0_wdata,
  output logic [WIDTH-1:0]  m0_rdata,
  input  logic              m1_wr,
  input  logic              m1_rd,
  input  logic [ADDR_W-1:0] m1_addr,
  input  logic [WIDTH-1:0]  m1_wdata,
  output logic [WIDTH-1:0]  m1_rdata,
  output logic [WIDTH-1:0]  gpio_out
);
  localparam int unsigned NMST = 2;

  logic              wr_v   [NMST];
  logic              rd_v   [NMST];
  logic [ADDR_W-1:0] addr_v [NMST];
  logic [WIDTH-1:0]  wd_v   [NMST];
  logic [WIDTH-1:0]  rdat_v [NMST];
  logic [NMST-1:0]   load_en;
  logic [WIDTH-1:0]  load_val [NMST];
  logic [WIDTH-1:0]  set_mask [NMST];
  logic [WIDTH-1:0]  clr_mask [NMST];
  logic [WIDTH-1:0]  dreg;

  assign wr_v[0] = m0_wr;  assign rd_v[0] = m0_rd;
  assign addr_v[0] = m0_addr; assign wd_v[0] = m0_wdata;
  assign wr_v[1] = m1_wr;  assign rd_v[1] = m1_rd;
  assign addr_v[1] = m1_addr; assign wd_v[1] = m1_wdata;
  assign m0_rdata = rdat_v[0];
  assign m1_rdata = rdat_v[1];

  for (genvar g = 0; g < NMST; g++) begin : g_port
    gpio_port_decode #(.WIDTH(WIDTH)) u_dec (
      .wr(wr_v[g]), .addr(addr_v[g]), .wdata(wd_v[g]),
      .load_en(load_en[g]), .load_val(load_val[g]),
      .set_mask(set_mask[g]), .clr_mask(clr_mask[g])
    );
    gpio_readback #(.WIDTH(WIDTH)) u_rb (
      .clk(clk), .rst(rst), .rd(rd_v[g]), .addr(addr_v[g]),
      .cur(dreg), .rdata(rdat_v[g])
    );
  end

  gpio_merge #(.WIDTH(WIDTH), .NMST(NMST)) u_merge (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
    .set_mask(set_mask), .clr_mask(clr_mask), .q(dreg)
  );

  assign gpio_out = dreg;

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    rst |=> (gpio_out == '0 && m0_rdata == '0 && m1_rdata == '0));
  // R5
  clr_beats_set_chk: assert property (@(posedge clk) disable iff (rst)
    (m0_wr && m0_addr == WA_SET && m1_wr && m1_addr == WA_CLR)
      |=> ((gpio_out & $past(m1_wdata)) == '0));
endmodule

// File: tb/test_gpio_dual_bank.sv
module test_gpio_dual_bank;
  localparam int W = 32;
  localparam logic [9:0] A_DATA = 10'h04F, A_CLR = 10'h064, A_SET = 10'h065, A_BAD = 10'h050;

  logic clk = 0, rst = 1;
  logic m0_wr = 0, m0_rd = 0, m1_wr = 0, m1_rd = 0;
  logic [9:0] m0_addr = 0, m1_addr = 0;
  logic [W-1:0] m0_wdata = 0, m1_wdata = 0;
  logic [W-1:0] m0_rdata, m1_rdata, gpio_out;

  int total = 0, bad = 0;
  logic [W-1:0] mdl = 0, exp_r0 = 0, exp_r1 = 0;

  always #5 clk = ~clk;

  gpio_dual_bank i_gpio_dual_bank (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rd_val(logic rd, logic [9:0] a, logic [W-1:0] cur);
    if (rd && (a == A_DATA || a == A_SET || a == A_CLR)) return cur;
    return '0;
  endfunction

  // drive one cycle on both ports, update model, then check after edge
  task automatic cyc(string req,
      logic w0, logic r0, logic [9:0] a0, logic [W-1:0] d0,
      logic w1, logic r1, logic [9:0] a1, logic [W-1:0] d1);
    logic [W-1:0] base, s, c;
    m0_wr = w0; m0_rd = r0; m0_addr = a0; m0_wdata = d0;
    m1_wr = w1; m1_rd = r1; m1_addr = a1; m1_wdata = d1;
    exp_r0 = rd_val(r0, a0, mdl);
    exp_r1 = rd_val(r1, a1, mdl);
    base = mdl; s = 0; c = 0;
    if (w1 && a1 == A_DATA) base = d1;
    if (w0 && a0 == A_DATA) base = d0;
    if (w0 && a0 == A_SET) s |= d0;
    if (w1 && a1 == A_SET) s |= d1;
    if (w0 && a0 == A_CLR) c |= d0;
    if (w1 && a1 == A_CLR) c |= d1;
    mdl = (base | s) & ~c;
    @(posedge clk); #2;
    chk({req, " pins"}, gpio_out, mdl);
    chk({req, " rd0"}, m0_rdata, exp_r0);
    chk({req, " rd1"}, m1_rdata, exp_r1);
    m0_wr = 0; m1_wr = 0; m0_rd = 0; m1_rd = 0;
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset values
    chk("R1 pins", gpio_out, '0);
    chk("R1 rd0", m0_rdata, '0);
    chk("R1 rd1", m1_rdata, '0);
    rst = 0;
    // R2 full word
    cyc("R2", 1,0,A_DATA,32'hA5A5_0F0F, 0,0,0,0);
    cyc("R2", 0,0,0,0, 1,0,A_DATA,32'h1234_5678);
    // R3 set alias
    cyc("R3", 1,0,A_SET,32'h8000_0001, 0,0,0,0);
    cyc("R3", 0,0,0,0, 1,0,A_SET,32'hFFFF_0000);
    // R4 clear alias
    cyc("R4", 1,0,A_CLR,32'h0000_00FF, 0,0,0,0);
    cyc("R4", 0,0,0,0, 1,0,A_CLR,32'hF000_0000);
    // R5 merge, disjoint bits and clear priority
    cyc("R5", 1,0,A_SET,32'h0000_0F00, 1,0,A_SET,32'h0000_00F0);
    cyc("R5", 1,0,A_SET,32'h0000_0003, 1,0,A_CLR,32'h0000_0001);
    cyc("R5", 1,0,A_CLR,32'h0000_0010, 1,0,A_SET,32'h0000_0030);
    // R6 load then masks
    cyc("R6", 1,0,A_DATA,32'h0000_FFFF, 1,0,A_SET,32'hFF00_0000);
    cyc("R6", 1,0,A_CLR,32'h0000_000F, 1,0,A_DATA,32'h0F0F_0F0F);
    // R7 both full-word
    cyc("R7", 1,0,A_DATA,32'hDEAD_BEEF, 1,0,A_DATA,32'h0BAD_F00D);
    // R8 read sees old value under same-cycle write
    cyc("R8", 1,1,A_CLR,32'hFFFF_FFFF, 0,1,A_SET,0);
    cyc("R8", 0,1,A_DATA,0, 1,1,A_DATA,32'h5555_AAAA);
    cyc("R8", 0,0,0,0, 0,1,A_CLR,0);
    // R9 stray address: no effect, reads zero
    cyc("R9", 1,1,A_BAD,32'hFFFF_FFFF, 1,1,10'h000,32'hFFFF_FFFF);
    // random concurrent traffic
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] a0, a1;
      int k0 = $urandom_range(0, 4), k1 = $urandom_range(0, 4);
      a0 = (k0 == 0) ? A_DATA : (k0 == 4) ? A_BAD : (k0[0] ? A_SET : A_CLR);
      a1 = (k1 == 0) ? A_DATA : (k1 == 4) ? A_BAD : (k1[0] ? A_SET : A_CLR);
      cyc("R5 rand", 1'($urandom), 1'($urandom), a0, $urandom,
                      1'($urandom), 1'($urandom), a1, $urandom);
    end
    rst = 1;
    @(posedge clk); #2;
    chk("R1 rereset", gpio_out, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule